// File: doc/BRIEF.md
# Gray-Code Stepper Phase Counter

This block is a synchronous position counter whose outputs are the phase lines of a stepper motor. The position is presented as a Gray code, so any single step moves exactly one phase line. A two-bit mode input chooses, on each step, between four actions: return to the home position, step clockwise, step counter-clockwise, or jump to a second fixed position (the preset). Nothing happens unless the step-enable input is high on a clock edge, so one enable pulse is one motor step.

A position-valid flag reports whether the position has been referenced. It rises when the counter is loaded with either fixed position and is cleared only by reset. Stepping in either direction leaves it unchanged. The code width and the preset code are parameters. An active-low asynchronous reset puts the counter at home and clears the flag without needing a clock edge.

Top module: `gray_stepper_counter`

## Requirements
- R1: Every clockwise or counter-clockwise step changes exactly one bit of `phaseCode`.
- R2: With `stepEn` high and `mode` = 2'b00, the next clock edge sets `phaseCode` to the home code, all zeros.
- R3: With `stepEn` high and `mode` = 2'b01, each clock edge moves `phaseCode` forward through 00, 01, 11, 10 (default width). After 10 it wraps to 00.
- R4: With `stepEn` high and `mode` = 2'b10, each clock edge moves `phaseCode` backward through 00, 10, 11, 01. After 01 it wraps to 00.
- R5: With `stepEn` high and `mode` = 2'b11, the next clock edge sets `phaseCode` to the `PRESET_GRAY` parameter. The default is 2'b11.
- R6: With `stepEn` low, `phaseCode` and `posValid` hold their values whatever `mode` is.
- R7: While `rstN` is low, `phaseCode` is all zeros and `posValid` is 0. This takes effect at once, without a clock edge, and whatever `stepEn` and `mode` are.
- R8: `posValid` goes to 1 on the edge that performs a home or preset load. It stays at 1 through steps and holds until reset. Steps alone never set it.
- R9: A clockwise step followed by a counter-clockwise step returns `phaseCode` to its starting code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Step enable: the selected action happens on an edge where this is high |
| mode | input | 2 | 00 home, 01 clockwise, 10 counter-clockwise, 11 preset |
| phaseCode | output | CODE_W | Registered Gray-code position, drives the phase lines |
| posValid | output | 1 | Position has been referenced by a home or preset load |

## Verification
Two functions can fall in the same cycle: the asynchronous reset, and a preset load that is armed for the coming edge. To provoke this, the bench sets `mode` = 11 with `stepEn` high, then pulls `rstN` low partway through the cycle. It first checks that the outputs go to home with the flag cleared before any edge arrives. It then checks that they stay there across the edge. After release, the next clockwise step must come out of home with `posValid` still 0, which shows that the pending preset was discarded. The one-bit-change rule is judged on every counting step against the code that was seen on the cycle before.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef enum logic [1:0] {
    MODE_HOME   = 2'b00,
    MODE_CW     = 2'b01,
    MODE_CCW    = 2'b10,
    MODE_PRESET = 2'b11
  } stepModeE;

  typedef struct packed {
    logic loadHome;
    logic loadPreset;
    logic stepFwd;
    logic stepRev;
  } stepStrobeT;

endpackage

// File: rtl/stepper_ctrl.sv
module stepper_ctrl
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic [1:0] mode,
  output stepStrobeT strobe,
  output logic       posValid
);

  stepModeE modeSel;
  logic     armed;

  assign modeSel = stepModeE'(mode);

  always_comb begin
    strobe = '0;
    if (stepEn) begin
      unique case (modeSel)
        MODE_HOME:   strobe.loadHome   = 1'b1;
        MODE_CW:     strobe.stepFwd    = 1'b1;
        MODE_CCW:    strobe.stepRev    = 1'b1;
        MODE_PRESET: strobe.loadPreset = 1'b1;
        default:     strobe            = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posValid <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (strobe.loadHome || strobe.loadPreset) posValid <= 1'b1;
    end
  end

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    posValid |=> posValid);

  // R8
  valid_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && (mode == 2'b00 || mode == 2'b11)) |=> posValid);

  // R8
  valid_not_from_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(posValid) && !($past(stepEn) && ($past(mode) == 2'b00 || $past(mode) == 2'b11)))
      |-> !posValid);

endmodule

// File: rtl/stepper_datapath.sv
module stepper_datapath
  import stepper_pkg::*;
#(
  parameter int                CODE_W      = 2,
  parameter logic [CODE_W-1:0] PRESET_GRAY = {CODE_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobeT        strobe,
  output logic [CODE_W-1:0] phaseCode
);

  function automatic logic [CODE_W-1:0] grayToBin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  localparam logic [CODE_W-1:0] PRESET_BIN = grayToBin(PRESET_GRAY);
  localparam logic [CODE_W-1:0] HOME_BIN   = '0;

  logic [CODE_W-1:0] binIndex;
  logic [CODE_W-1:0] binNext;
  logic [CODE_W-1:0] grayNext;
  logic              armed;

  always_comb begin
    if (strobe.loadHome)        binNext = HOME_BIN;
    else if (strobe.loadPreset) binNext = PRESET_BIN;
    else if (strobe.stepFwd)    binNext = binIndex + 1'b1;
    else if (strobe.stepRev)    binNext = binIndex - 1'b1;
    else                        binNext = binIndex;
  end

  assign grayNext = binNext ^ (binNext >> 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      binIndex  <= HOME_BIN;
      phaseCode <= '0;
      armed     <= 1'b0;
    end else begin
      binIndex  <= binNext;
      phaseCode <= grayNext;
      armed     <= 1'b1;
    end
  end

  // R1
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && ($past(strobe.stepFwd) || $past(strobe.stepRev)))
      |-> ($countones(phaseCode ^ $past(phaseCode)) == 1));

  // R2
  home_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHome |=> (phaseCode == '0));

  // R5
  preset_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPreset |=> (phaseCode == PRESET_GRAY));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(phaseCode));

endmodule

// File: rtl/gray_stepper_counter.sv
module gray_stepper_counter
  import stepper_pkg::*;
#(
  parameter int                CODE_W      = 2,
  parameter logic [CODE_W-1:0] PRESET_GRAY = {CODE_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [1:0]        mode,
  output logic [CODE_W-1:0] phaseCode,
  output logic              posValid
);

  stepStrobeT strobe;

  stepper_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stepEn   (stepEn),
    .mode     (mode),
    .strobe   (strobe),
    .posValid (posValid)
  );

  stepper_datapath #(
    .CODE_W      (CODE_W),
    .PRESET_GRAY (PRESET_GRAY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .phaseCode (phaseCode)
  );

  // R7
  reset_home_chk: assert property (@(posedge clk)
    !rstN |-> (phaseCode == '0 && !posValid));

endmodule

// File: tb/sim_gray_stepper_counter.sv
module sim_gray_stepper_counter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepEn = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] phaseCode;
  logic       posValid;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] ph;
    logic       vld;
    logic       isStep;
    string      tag;
  } expItemT;

  expItemT expQ[$];

  // Forward order of the default 2-bit code: 00, 01, 11, 10
  logic [1:0] seqTbl [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
  int         modelIdx = 0;
  logic       modelVld = 1'b0;
  logic [1:0] lastPhase = 2'b00;

  always #4 clk = ~clk;

  gray_stepper_counter u0 (
    .clk       (clk),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .mode      (mode),
    .phaseCode (phaseCode),
    .posValid  (posValid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: one call is one cycle of stimulus and one expected item
  task automatic drive(input logic [1:0] m, input logic en, input string tag);
    expItemT it;
    @(negedge clk);
    mode   = m;
    stepEn = en;
    if (en) begin
      case (m)
        2'b00: begin modelIdx = 0; modelVld = 1'b1; end
        2'b01: modelIdx = (modelIdx + 1) % 4;
        2'b10: modelIdx = (modelIdx + 3) % 4;
        default: begin modelIdx = 2; modelVld = 1'b1; end
      endcase
    end
    it.ph     = seqTbl[modelIdx];
    it.vld    = modelVld;
    it.isStep = en && (m == 2'b01 || m == 2'b10);
    it.tag    = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares one expected item per clock edge
  always @(posedge clk) begin
    expItemT it;
    #1;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      check(phaseCode == it.ph, it.tag, "phaseCode", int'(phaseCode), int'(it.ph));
      check(posValid == it.vld, it.tag, "posValid", int'(posValid), int'(it.vld));
      if (it.isStep)
        check($countones(phaseCode ^ lastPhase) == 1, "R1", "bits changed",
              $countones(phaseCode ^ lastPhase), 1);
    end
    lastPhase = phaseCode;
  end

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    #3;
    check(phaseCode == 2'b00, "R7", "phaseCode in reset", int'(phaseCode), 0);
    check(posValid == 1'b0, "R7", "posValid in reset", int'(posValid), 0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R6: no enable, no change
    drive(2'b01, 1'b0, "R6");
    drive(2'b11, 1'b0, "R6");
    // R3: forward with wrap, flag stays low (R8)
    drive(2'b01, 1'b1, "R3");
    drive(2'b01, 1'b1, "R3");
    drive(2'b01, 1'b1, "R3");
    drive(2'b01, 1'b1, "R3 wrap");
    // R2: home load sets the flag (R8)
    drive(2'b00, 1'b1, "R2");
    // R4: backward with wrap
    drive(2'b10, 1'b1, "R4 wrap");
    drive(2'b10, 1'b1, "R4");
    drive(2'b10, 1'b1, "R4");
    drive(2'b10, 1'b1, "R4");
    // R5: preset
    drive(2'b11, 1'b1, "R5");
    drive(2'b00, 1'b0, "R6");
    // R9: forward then back
    drive(2'b01, 1'b1, "R9");
    drive(2'b10, 1'b1, "R9");
    drive(2'b10, 1'b0, "R6");
    drive(2'b00, 1'b1, "R2");
    drive(2'b11, 1'b1, "R5");
    @(negedge clk);
    stepEn = 1'b0;
    @(posedge clk);
    #2;

    // R7: reset asserted while a preset load is armed
    @(negedge clk);
    mode   = 2'b11;
    stepEn = 1'b1;
    #2;
    rstN = 1'b0;
    #1;
    check(phaseCode == 2'b00, "R7", "phaseCode async", int'(phaseCode), 0);
    check(posValid == 1'b0, "R7", "posValid async", int'(posValid), 0);
    @(posedge clk);
    #2;
    check(phaseCode == 2'b00, "R7", "phaseCode over edge", int'(phaseCode), 0);
    check(posValid == 1'b0, "R7", "posValid over edge", int'(posValid), 0);
    @(negedge clk);
    stepEn   = 1'b0;
    rstN     = 1'b1;
    modelIdx = 0;
    modelVld = 1'b0;
    // R8: after reset, a step alone leaves the flag low
    drive(2'b01, 1'b1, "R8");
    @(negedge clk);
    stepEn = 1'b0;
    repeat (2) @(posedge clk);
    #2;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule